// File: doc/BRIEF.md
# Serial DAC Input Front End

This block is the digital front end of a sigma-delta current-loop DAC. A host drives three slow serial lines (a bit clock, a data line and a load strobe), and the block gathers a 16-bit code that a downstream modulator turns into loop current or voltage. All external lines are first synchronized to the system clock, and their edges are detected in that domain. Bits enter the input shift register most significant first on each rising bit-clock edge. A rising edge on the load strobe copies the whole input register, in parallel, into the holding register that feeds the modulator.

The bit that leaves the top of the input register is presented on a serial output after the following falling bit-clock edge. The next device in a chain can therefore sample it on its own rising edge, and any number of devices can be cascaded. An asynchronous clear forces the modulator code to the bottom of the chosen range at once. The code stays there after clear is released, until the next load. Clear never touches the input register. A two-bit range selector is synchronized and passed to the modulator beside the code.

The control state machine has four states. POWERUP is entered from reset and holds the code at minimum. ACTIVE is entered from POWERUP or PARKED on a load edge and drives the held word. CLEARING is entered from any state while the synchronized clear is high. PARKED is entered from CLEARING when clear drops and holds the minimum until the next load edge.

Top module: `serial_dac_frontend`

## Requirements
- R1: While reset is asserted and straight after it is released, code_o is 0, sdo_o is 0 and range_o is 0.
- R2: Sixteen rising edges of sclk_i shift in sdi_i most significant bit first. A rising edge of latch_i then makes code_o equal that word within 6 system cycles.
- R3: Shifting bits without a latch_i rising edge leaves code_o unchanged.
- R4: sdo_o changes only after a falling sclk_i edge. It then shows the bit that left the top of the input register on the preceding rising edge, so the first bit of a word appears on sdo_o after the 17th rising edge that follows it.
- R5: While clear_i is high, code_o is 0, which is the low end of every range, with no system-clock delay.
- R6: After clear_i falls, code_o stays 0 until a new latch_i rising edge. A latch_i edge seen while clear is high, including one in the same cycle as the clear edge, is ignored.
- R7: Clear does not alter the input register. A latch_i rising edge after clear, with no new bits shifted, makes code_o equal the word shifted in before the clear.
- R8: range_o follows range_i within 4 system cycles and does not disturb code_o. The encodings are 00 = 4 to 20 mA, 01 = 0 to 20 mA, 10 = 0 to 24 mA and 11 = voltage output.
- R9: After reset and before the first latch_i rising edge, code_o stays 0 whatever is shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial bit clock |
| sdi_i | input | 1 | Serial data in |
| latch_i | input | 1 | Load strobe; a rising edge transfers the input register |
| clear_i | input | 1 | Asynchronous clear to the range minimum |
| range_i | input | 2 | Range select |
| sdo_o | output | 1 | Serial data out for cascading |
| code_o | output | 16 | Code to the modulator |
| range_o | output | 2 | Synchronized range to the modulator |

## Verification
The load edge and the clear can be detected in the same system cycle. Both pass through identical synchronizers, so the bench raises latch_i and clear_i in the same clock period and they reach the state machine together. The case is judged correct when code_o stays 0 through clear, stays 0 after clear drops, and a later load with no new shifting yields the word that was shifted in before the clear.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
    typedef enum logic [1:0] {
        ST_POWERUP  = 2'd0,
        ST_ACTIVE   = 2'd1,
        ST_CLEARING = 2'd2,
        ST_PARKED   = 2'd3
    } ctl_state_e;

    typedef enum logic [1:0] {
        RNG_4_20 = 2'b00,
        RNG_0_20 = 2'b01,
        RNG_0_24 = 2'b10,
        RNG_VOLT = 2'b11
    } range_e;
endpackage

// File: rtl/sdf_sync.sv
module sdf_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= async_i;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/sdf_edge.sv
module sdf_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o,
    output logic fall_o
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= level_i;
        end
    end

    assign rise_o = level_i & ~prev_q;
    assign fall_o = ~level_i & prev_q;
endmodule

// File: rtl/sdf_shift.sv
module sdf_shift #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_i,
    input  logic              take_i,
    input  logic              emit_i,
    output logic [WORD_W-1:0] word_o,
    output logic              sdo_o
);
    logic [WORD_W-1:0] sreg_q;
    logic              pend_q;
    logic              sdo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
            pend_q <= 1'b0;
        end else if (take_i) begin
            sreg_q <= {sreg_q[WORD_W-2:0], bit_i};
            pend_q <= sreg_q[WORD_W-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sdo_q <= 1'b0;
        end else if (emit_i) begin
            sdo_q <= pend_q;
        end
    end

    assign word_o = sreg_q;
    assign sdo_o  = sdo_q;
endmodule

// File: rtl/sdf_ctrl.sv
module sdf_ctrl
    import sdf_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_evt_i,
    input  logic              clr_s_i,
    input  logic              clr_raw_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] code_o
);
    localparam logic [WORD_W-1:0] MIN_CODE = '0;

    ctl_state_e        state_q, state_d;
    logic [WORD_W-1:0] hold_q;
    logic              load_ok;

    always_comb begin
        state_d = state_q;
        if (clr_s_i) begin
            state_d = ST_CLEARING;
        end else begin
            unique case (state_q)
                ST_POWERUP:  if (ld_evt_i) state_d = ST_ACTIVE;
                ST_ACTIVE:   state_d = ST_ACTIVE;
                ST_CLEARING: state_d = ST_PARKED;
                ST_PARKED:   if (ld_evt_i) state_d = ST_ACTIVE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_POWERUP;
        end else begin
            state_q <= state_d;
        end
    end

    assign load_ok = ld_evt_i && !clr_s_i && (state_q != ST_CLEARING);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= MIN_CODE;
        end else if (load_ok) begin
            hold_q <= word_i;
        end
    end

    always_comb begin
        if (clr_raw_i || state_q != ST_ACTIVE) begin
            code_o = MIN_CODE;
        end else begin
            code_o = hold_q;
        end
    end
endmodule

// File: rtl/serial_dac_frontend.sv
module serial_dac_frontend #(
    parameter int WORD_W      = 16,
    parameter int SYNC_STAGES = 2,
    parameter int RANGE_W     = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_i,
    input  logic               sdi_i,
    input  logic               latch_i,
    input  logic               clear_i,
    input  logic [RANGE_W-1:0] range_i,
    output logic               sdo_o,
    output logic [WORD_W-1:0]  code_o,
    output logic [RANGE_W-1:0] range_o
);
    localparam int SYNC_W = 4 + RANGE_W;

    logic [SYNC_W-1:0] raw_in, syn_out;
    logic sclk_s, sdi_s, latch_s, clr_s;
    logic sclk_rise, sclk_fall, ld_evt, ld_fall_unused;
    logic [WORD_W-1:0] in_word;

    assign raw_in = {range_i, clear_i, latch_i, sdi_i, sclk_i};

    sdf_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .async_i(raw_in), .sync_o(syn_out)
    );

    assign sclk_s  = syn_out[0];
    assign sdi_s   = syn_out[1];
    assign latch_s = syn_out[2];
    assign clr_s   = syn_out[3];
    assign range_o = syn_out[SYNC_W-1:4];

    sdf_edge sclk_edge_i (
        .clk(clk), .rst_n(rst_n), .level_i(sclk_s),
        .rise_o(sclk_rise), .fall_o(sclk_fall)
    );

    sdf_edge latch_edge_i (
        .clk(clk), .rst_n(rst_n), .level_i(latch_s),
        .rise_o(ld_evt), .fall_o(ld_fall_unused)
    );

    sdf_shift #(.WORD_W(WORD_W)) shift_i (
        .clk(clk), .rst_n(rst_n), .bit_i(sdi_s),
        .take_i(sclk_rise), .emit_i(sclk_fall),
        .word_o(in_word), .sdo_o(sdo_o)
    );

    sdf_ctrl #(.WORD_W(WORD_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .ld_evt_i(ld_evt), .clr_s_i(clr_s),
        .clr_raw_i(clear_i), .word_i(in_word), .code_o(code_o)
    );
endmodule

// File: rtl/sdf_checker.sv
module sdf_checker #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clear_i,
    input logic [WORD_W-1:0] code_o,
    input logic              sdo_o,
    input logic              ld_evt,
    input logic              clr_s,
    input logic              sclk_fall
);
    // R5
    clear_forces_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |-> (code_o == '0));

    // R3
    code_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_evt && !clear_i && !clr_s) |=> ($stable(code_o) || clear_i));

    // R6
    min_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_o == '0 && !ld_evt) |=> (code_o == '0));

    // R4
    sdo_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_fall |=> $stable(sdo_o));
endmodule

bind serial_dac_frontend sdf_checker #(.WORD_W(WORD_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .code_o(code_o),
    .sdo_o(sdo_o), .ld_evt(ld_evt), .clr_s(clr_s), .sclk_fall(sclk_fall)
);

// File: tb/serial_dac_frontend_tb_top.sv
module serial_dac_frontend_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, sdi = 1'b0, latch = 1'b0, clr = 1'b0;
    logic [1:0] rng = 2'b00;
    logic sdo;
    logic [15:0] code;
    logic [1:0] rng_o;

    int checks = 0;
    int errors = 0;
    logic [15:0] model = '0;
    logic [15:0] last_word = '0;

    always #4 clk = ~clk;

    serial_dac_frontend dut_i (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdi_i(sdi),
        .latch_i(latch), .clear_i(clr), .range_i(rng),
        .sdo_o(sdo), .code_o(code), .range_o(rng_o)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_word(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) begin
            logic out_bit;
            sdi = w[i];
            cyc(4);
            sclk = 1'b1;
            out_bit = model[15];
            model = {model[14:0], w[i]};
            cyc(4);
            sclk = 1'b0;
            cyc(4);
            chk("R4 sdo bit", {15'd0, sdo}, {15'd0, out_bit});
        end
    endtask

    task automatic pulse_latch();
        latch = 1'b1;
        cyc(6);
        latch = 1'b0;
        cyc(6);
    endtask

    initial begin
        logic [15:0] w;
        cyc(3);
        chk("R1 code in reset", code, 16'h0);
        chk("R1 sdo in reset", {15'd0, sdo}, 16'h0);
        chk("R1 range in reset", {14'd0, rng_o}, 16'h0);
        rst_n = 1'b1;
        cyc(2);
        chk("R1 code after reset", code, 16'h0);

        shift_word(16'hA5C3);
        chk("R9 no latch yet", code, 16'h0);
        pulse_latch();
        chk("R2 first load", code, 16'hA5C3);
        last_word = 16'hA5C3;

        for (int k = 0; k < 16; k++) begin
            w = 16'h1 << k;
            shift_word(w);
            chk("R3 code unchanged before load", code, last_word);
            pulse_latch();
            chk("R2 walking one", code, w);
            last_word = w;
        end
        for (int k = 0; k < 8; k++) begin
            w = (16'h9E37 * (k + 3)) ^ (16'h00FF << k);
            shift_word(w);
            pulse_latch();
            chk("R2 pattern", code, w);
            last_word = w;
        end
        shift_word(16'hFFFF);
        pulse_latch();
        chk("R2 all ones", code, 16'hFFFF);
        shift_word(16'h0000);
        pulse_latch();
        chk("R2 all zeros", code, 16'h0000);
        shift_word(16'h7E81);
        pulse_latch();
        last_word = 16'h7E81;

        shift_word(16'h3C5A);
        clr = 1'b1;
        #1;
        chk("R5 immediate clear", code, 16'h0);
        cyc(6);
        pulse_latch();
        chk("R6 load ignored during clear", code, 16'h0);
        clr = 1'b0;
        cyc(8);
        chk("R6 stays min after clear", code, 16'h0);
        pulse_latch();
        chk("R7 input register kept", code, 16'h3C5A);

        latch = 1'b1;
        clr = 1'b1;
        cyc(6);
        chk("R6 same cycle clear and load", code, 16'h0);
        clr = 1'b0;
        cyc(6);
        latch = 1'b0;
        cyc(6);
        chk("R6 min after same-cycle case", code, 16'h0);
        pulse_latch();
        chk("R7 word after same-cycle case", code, 16'h3C5A);

        for (int r = 0; r < 4; r++) begin
            rng = r[1:0];
            cyc(4);
            chk("R8 range follows", {14'd0, rng_o}, r[15:0]);
            chk("R8 code untouched", code, 16'h3C5A);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule